// File: doc/BRIEF.md
# Multi-Bank Selectable Clock Divider

This block derives three banks of clocks from one fast source clock. Every output runs at a ratio chosen by pins. The source is either the fast clock itself, one advance per clock cycle, or a reference strobe that is synchronous to the fast clock. In that second mode each cycle with the strobe high counts as one source cycle. An optional divide-by-two stage comes next. Each bank then divides by one of its own two ratios. Every ratio is even, so each bank output is high for exactly half of its period.

A master-off input holds every divider in its cleared state, drives every clock pin low and drops the per-bank enable flags. The enable flags stand in for the high-impedance state of real pads. When master-off is released, all three bank counters start from the same phase. Their first rising edges therefore fall in the same cycle, and later rising edges stay aligned on the common period. The counters correct themselves from any starting value, so correct operation needs no reset at power-up.

Top module: `clkdiv_multibank`

## Requirements
- R1: With `pre_div2` = 0 the banks advance once per source cycle. With `pre_div2` = 1 a divide-by-two stage is inserted, and the banks advance on every second source cycle. That stage is cleared by master-off and steps on every source cycle whatever the value of `pre_div2`. The banks advance on the source cycles where its state was 1, so the first advance comes on the second source cycle after release.
- R2: Bank A drives five identical pins and divides the advance rate by 4 when `sel_a` = 0 and by 6 when `sel_a` = 1.
- R3: Bank B drives four identical pins and divides by 4 when `sel_b` = 0 and by 2 when `sel_b` = 1.
- R4: Bank C drives two identical pins and divides by 2 when `sel_c` = 0 and by 4 when `sel_c` = 1.
- R5: For a ratio N, a bank output is high for N/2 advances and low for N/2 advances. It is low after release until the first advance, which drives it high; the new value is visible after the clock edge that makes the advance.
- R6: While `master_off` = 1, every clock pin reads 0 and every bank enable reads 0 in the same cycle, and all divider state is cleared on each clock edge. While it is 0, the enables read 1.
- R7: With `use_ref` = 1, a source cycle is a fast-clock cycle with `ref_strobe` = 1. With `use_ref` = 0, every fast-clock cycle is a source cycle and `ref_strobe` has no effect on the outputs.
- R8: After release, all three banks rise together at the first advance. Rising edges of all banks coincide again at every multiple of their common period.
- R9: Without any master-off pulse from power-up, the outputs settle to the periods and 50% duty of R2 to R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk | input | 1 | Fast source clock; all state is clocked on its rising edge |
| ref_strobe | input | 1 | Reference cycle strobe used as the source in bypass mode |
| use_ref | input | 1 | 1 selects the reference strobe as the source, 0 the fast clock |
| pre_div2 | input | 1 | 1 inserts the divide-by-two stage ahead of the banks |
| master_off | input | 1 | 1 clears the dividers and disables every output |
| sel_a | input | 1 | Bank A ratio select (0: /4, 1: /6) |
| sel_b | input | 1 | Bank B ratio select (0: /4, 1: /2) |
| sel_c | input | 1 | Bank C ratio select (0: /2, 1: /4) |
| bank_a_clk | output | 5 | Bank A clock pins |
| bank_a_oe | output | 1 | Bank A drive enable (0 models high impedance) |
| bank_b_clk | output | 4 | Bank B clock pins |
| bank_b_oe | output | 1 | Bank B drive enable |
| bank_c_clk | output | 2 | Bank C clock pins |
| bank_c_oe | output | 1 | Bank C drive enable |

## Verification
Two cases put two functions in one cycle. In the first, master-off is released in the same cycle as a reference strobe in bypass mode. In the second, master-off is raised in a cycle where bank A is high. The bench provokes the first by starting every bypass run with the strobe high in its release cycle, and the behavioural model must then credit that strobe as the first source cycle. For the second, the bench raises master-off at a moment when bank A reads high. The pins and enables must then read 0 before the next clock edge, and the next run must again start with all three banks aligned.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic bit ratio_ok(input int r);
      return (r >= 2) && ((r % 2) == 0);
   endfunction

   function automatic int cnt_width(input int r);
      return (r > 2) ? $clog2(r) : 1;
   endfunction

endpackage

// File: rtl/clkdiv_src_sel.sv
module clkdiv_src_sel #(
   parameter int PRE_RATIO = 2
) (
   input  logic fast_clk,
   input  logic hold,
   input  logic use_ref,
   input  logic ref_strobe,
   input  logic pre_div2,
   output logic adv_tick
);
   localparam int PW = clkdiv_pkg::cnt_width(PRE_RATIO);

   logic src_adv;
   logic pre_hit;

   if (PRE_RATIO < 2) begin : g_bad_ratio
      $error("clkdiv_src_sel: PRE_RATIO must be at least 2");
   end

   assign src_adv = use_ref ? ref_strobe : 1'b1;

   if (PRE_RATIO == 2) begin : g_toggle
      logic ph;
      always_ff @(posedge fast_clk) begin
         if (hold)         ph <= 1'b0;
         else if (src_adv) ph <= ~ph;
      end
      assign pre_hit = ph;
   end else begin : g_count
      logic [PW-1:0] pcnt;
      always_ff @(posedge fast_clk) begin
         if (hold) pcnt <= '0;
         else if (src_adv) begin
            if (pcnt == PW'(PRE_RATIO - 1)) pcnt <= '0;
            else                            pcnt <= pcnt + 1'b1;
         end
      end
      assign pre_hit = (pcnt == PW'(PRE_RATIO - 1));
   end

   assign adv_tick = src_adv & (~pre_div2 | pre_hit);

   AST_PREDIV_GAP: assert property (@(posedge fast_clk) disable iff (hold)
      (pre_div2 && adv_tick) |=> (!adv_tick || !pre_div2)); // R1

   AST_DIRECT_RATE: assert property (@(posedge fast_clk) disable iff (hold)
      (!use_ref && !pre_div2) |-> adv_tick); // R1

   AST_REF_GATE: assert property (@(posedge fast_clk) disable iff (hold)
      (use_ref && !ref_strobe) |-> !adv_tick); // R7

endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank #(
   parameter int RATIO_SEL0 = 4,
   parameter int RATIO_SEL1 = 6,
   parameter int NUM_OUT    = 5
) (
   input  logic               fast_clk,
   input  logic               hold,
   input  logic               adv_tick,
   input  logic               ratio_sel,
   output logic [NUM_OUT-1:0] bank_clk,
   output logic               bank_en
);
   localparam int RMAX = clkdiv_pkg::max_of(RATIO_SEL0, RATIO_SEL1);
   localparam int CW   = clkdiv_pkg::cnt_width(RMAX);

   logic q;

   if (!clkdiv_pkg::ratio_ok(RATIO_SEL0) || !clkdiv_pkg::ratio_ok(RATIO_SEL1)) begin : g_bad_ratio
      $error("clkdiv_bank: ratios must be even and at least 2");
   end
   if (NUM_OUT < 1) begin : g_bad_outs
      $error("clkdiv_bank: NUM_OUT must be at least 1");
   end

   if (RMAX == 2) begin : g_toggle
      always_ff @(posedge fast_clk) begin
         if (hold)          q <= 1'b0;
         else if (adv_tick) q <= ~q;
      end
   end else begin : g_count
      logic [CW-1:0] cnt;
      logic [CW-1:0] last;
      logic [CW-1:0] half;

      assign last = ratio_sel ? CW'(RATIO_SEL1 - 1) : CW'(RATIO_SEL0 - 1);
      assign half = ratio_sel ? CW'(RATIO_SEL1 / 2) : CW'(RATIO_SEL0 / 2);

      always_ff @(posedge fast_clk) begin
         if (hold) begin
            cnt <= '0;
            q   <= 1'b0;
         end else if (adv_tick) begin
            if (cnt >= last) cnt <= '0;
            else             cnt <= cnt + 1'b1;
            q <= (cnt < half);
         end
      end

      AST_RISE_AT_ZERO: assert property (@(posedge fast_clk) disable iff (hold)
         $rose(q) |-> ($past(cnt) == '0)); // R5
   end

   AST_IDLE_STABLE: assert property (@(posedge fast_clk) disable iff (hold)
      !adv_tick |=> $stable(q)); // R5

   for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
      assign bank_clk[g] = q & ~hold;
   end
   assign bank_en = ~hold;

endmodule

// File: rtl/clkdiv_multibank.sv
module clkdiv_multibank #(
   parameter int PRE_RATIO = 2,
   parameter int A_OUTS    = 5,
   parameter int A_SEL0    = 4,
   parameter int A_SEL1    = 6,
   parameter int B_OUTS    = 4,
   parameter int B_SEL0    = 4,
   parameter int B_SEL1    = 2,
   parameter int C_OUTS    = 2,
   parameter int C_SEL0    = 2,
   parameter int C_SEL1    = 4
) (
   input  logic              fast_clk,
   input  logic              ref_strobe,
   input  logic              use_ref,
   input  logic              pre_div2,
   input  logic              master_off,
   input  logic              sel_a,
   input  logic              sel_b,
   input  logic              sel_c,
   output logic [A_OUTS-1:0] bank_a_clk,
   output logic              bank_a_oe,
   output logic [B_OUTS-1:0] bank_b_clk,
   output logic              bank_b_oe,
   output logic [C_OUTS-1:0] bank_c_clk,
   output logic              bank_c_oe
);
   logic adv_tick;

   clkdiv_src_sel #(.PRE_RATIO(PRE_RATIO)) u_src (
      .fast_clk   (fast_clk),
      .hold       (master_off),
      .use_ref    (use_ref),
      .ref_strobe (ref_strobe),
      .pre_div2   (pre_div2),
      .adv_tick   (adv_tick)
   );

   clkdiv_bank #(.RATIO_SEL0(A_SEL0), .RATIO_SEL1(A_SEL1), .NUM_OUT(A_OUTS)) u_bank_a (
      .fast_clk (fast_clk), .hold (master_off), .adv_tick (adv_tick),
      .ratio_sel (sel_a), .bank_clk (bank_a_clk), .bank_en (bank_a_oe)
   );

   clkdiv_bank #(.RATIO_SEL0(B_SEL0), .RATIO_SEL1(B_SEL1), .NUM_OUT(B_OUTS)) u_bank_b (
      .fast_clk (fast_clk), .hold (master_off), .adv_tick (adv_tick),
      .ratio_sel (sel_b), .bank_clk (bank_b_clk), .bank_en (bank_b_oe)
   );

   clkdiv_bank #(.RATIO_SEL0(C_SEL0), .RATIO_SEL1(C_SEL1), .NUM_OUT(C_OUTS)) u_bank_c (
      .fast_clk (fast_clk), .hold (master_off), .adv_tick (adv_tick),
      .ratio_sel (sel_c), .bank_clk (bank_c_clk), .bank_en (bank_c_oe)
   );

endmodule

// File: tb/sim_clkdiv_multibank.sv
module sim_clkdiv_multibank;
   logic       fast_clk = 1'b0;
   logic       ref_strobe = 1'b0, use_ref = 1'b0, pre_div2 = 1'b0, master_off = 1'b0;
   logic       sel_a = 1'b0, sel_b = 1'b0, sel_c = 1'b0;
   logic [4:0] bank_a_clk;
   logic [3:0] bank_b_clk;
   logic [1:0] bank_c_clk;
   logic       bank_a_oe, bank_b_oe, bank_c_oe;

   int  n_chk = 0, n_err = 0;
   bit  done = 0;
   bit  model_on = 0;
   int  adv_cnt = 0;
   int  ph = 0;
   int  lfsr = 32'h1d;

   always #4 fast_clk = ~fast_clk;

   clkdiv_multibank u0 (
      .fast_clk (fast_clk), .ref_strobe (ref_strobe), .use_ref (use_ref),
      .pre_div2 (pre_div2), .master_off (master_off),
      .sel_a (sel_a), .sel_b (sel_b), .sel_c (sel_c),
      .bank_a_clk (bank_a_clk), .bank_a_oe (bank_a_oe),
      .bank_b_clk (bank_b_clk), .bank_b_oe (bank_b_oe),
      .bank_c_clk (bank_c_clk), .bank_c_oe (bank_c_oe)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic bit exp_level(input int k, input int n);
      if (k == 0) return 1'b0;
      return ((k - 1) % n) < (n / 2);
   endfunction

   // behavioural reference: count bank advances since release
   always @(posedge fast_clk) begin
      if (master_off) begin
         adv_cnt = 0;
         ph = 0;
      end else if (use_ref ? ref_strobe : 1'b1) begin
         if (!pre_div2 || ph == 1) adv_cnt++;
         ph = (ph + 1) % 2;
      end
   end

   always @(negedge fast_clk) begin
      if (model_on) begin
         int na, nb, nc;
         bit ea, eb, ec;
         na = sel_a ? 6 : 4;
         nb = sel_b ? 2 : 4;
         nc = sel_c ? 4 : 2;
         if (master_off) begin
            check(bank_a_clk == 0 && bank_b_clk == 0 && bank_c_clk == 0, "R6 pins low",
                  {bank_a_clk, bank_b_clk, bank_c_clk}, 0);
            check({bank_a_oe, bank_b_oe, bank_c_oe} == 3'b000, "R6 enables low",
                  {bank_a_oe, bank_b_oe, bank_c_oe}, 0);
         end else begin
            ea = exp_level(adv_cnt, na);
            eb = exp_level(adv_cnt, nb);
            ec = exp_level(adv_cnt, nc);
            check({bank_a_oe, bank_b_oe, bank_c_oe} == 3'b111, "R6 enables high",
                  {bank_a_oe, bank_b_oe, bank_c_oe}, 7);
            check(bank_a_clk == {5{ea}}, use_ref ? "R2,R5,R7,R1" : "R2,R5,R1",
                  bank_a_clk, {5{ea}});
            check(bank_b_clk == {4{eb}}, "R3,R5", bank_b_clk, {4{eb}});
            check(bank_c_clk == {2{ec}}, "R4,R5", bank_c_clk, {2{ec}});
            if (adv_cnt > 0 && ((adv_cnt - 1) % 12) == 0)
               check(bank_a_clk[0] && bank_b_clk[0] && bank_c_clk[0], "R8 common rise",
                     {bank_a_clk[0], bank_b_clk[0], bank_c_clk[0]}, 7);
         end
      end
   end

   task automatic drive_point();
      @(negedge fast_clk);
      #2;
   endtask

   function automatic bit strobe_of(input int mode, input int i);
      if (mode == 0) return 1'b1;
      if (mode == 1) return (i % 3) == 0;
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
      return (i == 0) ? 1'b1 : lfsr[0];
   endfunction

   task automatic run_cfg(input bit vco, input bit sa, input bit sb, input bit sc,
                          input bit byp, input int mode, input int n);
      drive_point();
      master_off = 1'b1;
      drive_point();
      pre_div2 = vco; sel_a = sa; sel_b = sb; sel_c = sc; use_ref = byp;
      drive_point();
      master_off = 1'b0;
      ref_strobe = strobe_of(mode, 0);
      for (int i = 1; i < n; i++) begin
         drive_point();
         ref_strobe = strobe_of(mode, i);
      end
   endtask

   // power-up: no master-off pulse, measure periods and high times
   task automatic powerup_check();
      int  last_rise[3];
      int  hi_len[3];
      bit  prev[3];
      int  ratio[3];
      ratio = '{4, 4, 2};
      for (int b = 0; b < 3; b++) begin
         last_rise[b] = -1; hi_len[b] = 0; prev[b] = 0;
      end
      repeat (16) @(negedge fast_clk);
      for (int t = 0; t < 48; t++) begin
         bit v[3];
         @(negedge fast_clk);
         v[0] = bank_a_clk[0]; v[1] = bank_b_clk[0]; v[2] = bank_c_clk[0];
         for (int b = 0; b < 3; b++) begin
            if (v[b] && !prev[b]) begin
               if (last_rise[b] >= 0)
                  check(t - last_rise[b] == ratio[b], "R9 period", t - last_rise[b], ratio[b]);
               last_rise[b] = t;
               hi_len[b] = 0;
            end
            if (!v[b] && prev[b] && last_rise[b] >= 0)
               check(hi_len[b] == ratio[b] / 2, "R9 high time", hi_len[b], ratio[b] / 2);
            if (v[b]) hi_len[b]++;
            prev[b] = v[b];
         end
      end
   endtask

   initial begin
      powerup_check();
      model_on = 1;
      for (int c = 0; c < 16; c++)
         run_cfg(c[3], c[2], c[1], c[0], 1'b0, 2, 30);
      run_cfg(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1, 45);
      run_cfg(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 2, 60);
      run_cfg(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 0, 30);
      run_cfg(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2, 60);
      // raise master-off while bank A is high, check pins drop before the next edge
      for (int k = 0; k < 20 && !bank_a_clk[0]; k++) drive_point();
      check(bank_a_clk[0], "R6 precondition bank A high", bank_a_clk[0], 1);
      master_off = 1'b1;
      #1;
      check(bank_a_clk == 0 && bank_b_clk == 0 && bank_c_clk == 0, "R6 same-cycle off",
            {bank_a_clk, bank_b_clk, bank_c_clk}, 0);
      check({bank_a_oe, bank_b_oe, bank_c_oe} == 3'b000, "R6 same-cycle disable",
            {bank_a_oe, bank_b_oe, bank_c_oe}, 0);
      run_cfg(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2, 40);
      model_on = 0;
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule